// File: doc/BRIEF.md
# Cascaded Three-Word Event Interrupt Controller

This block gathers up to 96 single-cycle event pulses into three 32-bit pending words and turns them into three level interrupt lines, A, B and C. An event is reported as a strobe with a 7-bit index. The upper two index bits pick the pending word and the lower five pick the bit. Each interrupt line has its own mask register for every pending word. A line is high while any pending bit, in any word, is also set in that line's mask for that word.

Events landing in the two upper words also set summary bits in word 0, so a handler can mask at word 0 only. Bit 30 of word 0 stands for word 1 and bit 31 stands for word 2. Hardware owns these two bits: software writes cannot clear them. They fall only when their word drains. Software clears pending bits by writing ones. Word 1 cannot be cleared by software at all. A separate hardware clear request retires one event at a time.

Every mask write takes effect on the interrupt lines at once, at the same clock edge as the write itself. The lines are registered. They show the effect of a strobe, a clear or a write one cycle after it is presented.

Top module: `evt_cascade_irq`

## Requirements
- R1: Event index bits [6:5] select the pending word (0, 1 or 2) and bits [4:0] the bit in it. A strobe sets that bit, readable from the next cycle. An index whose word field is 3 changes nothing.
- R2: Line irq_o[0] (A), irq_o[1] (B) and irq_o[2] (C) are each high exactly when the OR over the three words of (pending AND that line's mask for the word) is non-zero. The lines are registered and reflect a strobe, clear or write one cycle after it.
- R3: A strobe to word 1 also sets bit 30 of word 0, and a strobe to word 2 also sets bit 31 of word 0. Both bits count toward the lines through the word-0 masks.
- R4: A write to pending word 0 clears every bit written as 1, except bits 31 and 30, which the write leaves unchanged.
- R5: Writes to pending word 1 are ignored.
- R6: A write to pending word 2 clears the bits written as 1. If word 2 is then all zero, bit 31 of word 0 is cleared in the same cycle.
- R7: A hardware clear request clears the one indexed bit. If its word is then zero, word 0 bit 30 (for word 1) or bit 31 (for word 2) is cleared in the same cycle.
- R8: A write to any of the nine mask registers re-evaluates all three lines at the same edge. A line may rise or fall one cycle after the write with no event present.
- R9: A synchronous active-low reset clears all pending and mask registers and holds all lines low.
- R10: When a strobe and a clear (software write or hardware request) hit the same bit in the same cycle, the bit ends up set.
- R11: Register address bits [3:2] select the bank (0 pending, 1 mask A, 2 mask B, 3 mask C) and bits [1:0] the word (0 to 2). Masks read back as written. Word field 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_idx | input | 7 | Event index: word in [6:5], bit in [4:0] |
| clr_valid | input | 1 | Hardware clear request for one event |
| clr_idx | input | 7 | Index of the event to clear, same layout as evt_idx |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address: bank in [3:2], word in [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_o | output | 3 | Interrupt levels: [0] A, [1] B, [2] C |

## Verification
Several of this block's functions can fall in the same cycle. The key pair is an event strobe and a clear of the same pending bit. The clear may come from a software write-one or from a hardware clear request. A second pair is a cascade bit being set and being drained at once. The bench provokes both pairs by driving the strobe together with the write or the clear request in one cycle. It then judges the result from two sources: the pending words read back through the register port, and the three interrupt lines one cycle later. The expected values come from a reference model of the stated rules, which gives the event precedence.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants for the cascaded event interrupt controller.
// Assumes exactly three pending words and three interrupt lines; the
// cascade summary bits depend on that fixed arrangement.
package evt_irq_pkg;
    localparam int NUM_WORDS = 3;
    localparam int NUM_OUTS  = 3;
    localparam int ADDR_W    = 4;

    // word selectors inside an event index or register address
    localparam logic [1:0] W_LOW  = 2'd0;
    localparam logic [1:0] W_MID  = 2'd1;
    localparam logic [1:0] W_HIGH = 2'd2;
    localparam logic [1:0] LAST_WORD = W_HIGH;

    // register bank selectors (address bits [3:2])
    localparam logic [1:0] BANK_PEND = 2'd0;
endpackage

// File: rtl/evt_pend_word.sv
// Module: one pending word. Clears are applied first and sets last, so a set
// in the same cycle always wins. Assumes the caller has already folded all
// clear sources (software, hardware, cascade) into clr_vec.
module evt_pend_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    output logic [WORD_W-1:0] cur_q,
    output logic [WORD_W-1:0] nxt
);
    // next value: clear first, then set
    always_comb begin
        nxt = (cur_q & ~clr_vec) | set_vec;
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt;
    end
endmodule

// File: rtl/evt_mask_bank.sv
// Module: the per-word mask registers of one interrupt line. Exposes both the
// stored value and the value it will hold after this edge, so the line can
// be re-evaluated in the same cycle as a mask write. Assumes wr_en is only
// raised for a valid word number.
module evt_mask_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int WSEL_W    = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [WSEL_W-1:0]                   wr_word,
    input  logic [WORD_W-1:0]                   wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    mask_q,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    mask_nxt
);
    // next mask values: the addressed word takes the write data
    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            mask_nxt[w] = (wr_en && wr_word == WSEL_W'(w)) ? wr_data : mask_q[w];
        end
    end

    // mask storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end
endmodule

// File: rtl/evt_irq_reduce.sv
// Module: reduces next-state pending and mask words to one registered level
// line. Assumes both inputs are next-state values so the line tracks the
// registers with exactly one cycle of latency.
module evt_irq_reduce #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] pend_nxt,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] mask_nxt,
    output logic                             irq_q
);
    logic hit;

    // OR over all words of pending AND mask
    always_comb begin
        hit = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            hit = hit | (|(pend_nxt[w] & mask_nxt[w]));
        end
    end

    // registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit;
    end
endmodule

// File: rtl/evt_cascade_irq.sv
// Module: top of the cascaded three-word event interrupt controller.
// Decodes event strobes, hardware clear requests and register writes into
// per-word set/clear vectors, keeps the word-0 cascade summary bits in step
// with words 1 and 2, holds three mask banks and drives three registered
// interrupt levels. Assumes one event and one clear request per cycle at most.
module evt_cascade_irq
    import evt_irq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [6:0]           evt_idx,
    input  logic                 clr_valid,
    input  logic [6:0]           clr_idx,
    input  logic                 reg_wr,
    input  logic [3:0]           reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [2:0]           irq_o
);
    localparam int BIT_W         = $clog2(WORD_W);
    localparam int IDX_W         = BIT_W + 2;
    localparam int CASC_HIGH_BIT = WORD_W - 1;
    localparam int CASC_MID_BIT  = WORD_W - 2;
    localparam logic [WORD_W-1:0] CASC_MASK = {2'b11, {(WORD_W-2){1'b0}}};

    logic [1:0]       ev_word, cl_word, reg_word, reg_bank;
    logic [BIT_W-1:0] ev_bit, cl_bit;
    logic             pend_wr;

    logic [NUM_WORDS-1:0][WORD_W-1:0] set_vec, clr_base, pend_q, pend_nxt;
    logic [WORD_W-1:0] clr_low, mid_left, high_left;
    logic              mid_touch, high_touch;
    logic [NUM_OUTS-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask_q, mask_nxt;

    assign ev_word  = evt_idx[IDX_W-1 -: 2];
    assign ev_bit   = evt_idx[BIT_W-1:0];
    assign cl_word  = clr_idx[IDX_W-1 -: 2];
    assign cl_bit   = clr_idx[BIT_W-1:0];
    assign reg_word = reg_addr[1:0];
    assign reg_bank = reg_addr[ADDR_W-1 -: 2];
    assign pend_wr  = reg_wr && reg_bank == BANK_PEND;

    // decode events and direct clears into per-word vectors
    always_comb begin
        set_vec  = '0;
        clr_base = '0;
        if (evt_valid && ev_word <= LAST_WORD) begin
            set_vec[ev_word][ev_bit] = 1'b1;
            if (ev_word == W_MID)  set_vec[W_LOW][CASC_MID_BIT]  = 1'b1;
            if (ev_word == W_HIGH) set_vec[W_LOW][CASC_HIGH_BIT] = 1'b1;
        end
        if (pend_wr) begin
            if (reg_word == W_LOW)       clr_base[W_LOW]  = reg_wdata & ~CASC_MASK;
            else if (reg_word == W_HIGH) clr_base[W_HIGH] = reg_wdata;
        end
        if (clr_valid && cl_word <= LAST_WORD) begin
            clr_base[cl_word][cl_bit] = 1'b1;
        end
    end

    // cascade drain: upper word emptied by a clear this cycle drops its summary bit
    always_comb begin
        mid_left   = (pend_q[W_MID]  & ~clr_base[W_MID])  | set_vec[W_MID];
        high_left  = (pend_q[W_HIGH] & ~clr_base[W_HIGH]) | set_vec[W_HIGH];
        high_touch = (pend_wr && reg_word == W_HIGH) || (clr_valid && cl_word == W_HIGH);
        mid_touch  = clr_valid && cl_word == W_MID;
        clr_low    = clr_base[W_LOW];
        if (high_touch && high_left == '0) clr_low[CASC_HIGH_BIT] = 1'b1;
        if (mid_touch  && mid_left  == '0) clr_low[CASC_MID_BIT]  = 1'b1;
    end

    // pending words
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        evt_pend_word #(.WORD_W(WORD_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_vec[w]),
            .clr_vec ((w == 0) ? clr_low : clr_base[w]),
            .cur_q   (pend_q[w]),
            .nxt     (pend_nxt[w])
        );
    end

    // one mask bank and one reducer per interrupt line
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
        evt_mask_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WSEL_W(2)) u_mask (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && reg_bank == 2'(o + 1) && reg_word <= LAST_WORD),
            .wr_word  (reg_word),
            .wr_data  (reg_wdata),
            .mask_q   (mask_q[o]),
            .mask_nxt (mask_nxt[o])
        );
        evt_irq_reduce #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_reduce (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_nxt (pend_nxt),
            .mask_nxt (mask_nxt[o]),
            .irq_q    (irq_o[o])
        );

        // R2: each line agrees with the stored pending and mask state
        a_r2_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[o] == (|(pend_q & mask_q[o])));
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_word <= LAST_WORD) begin
            if (reg_bank == BANK_PEND) begin
                reg_rdata = pend_q[reg_word];
            end else begin
                for (int o = 0; o < NUM_OUTS; o++) begin
                    if (reg_bank == 2'(o + 1)) reg_rdata = mask_q[o][reg_word];
                end
            end
        end
    end

    // R1: a valid strobe leaves its bit set on the next cycle
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ev_word <= LAST_WORD) |=> pend_q[$past(ev_word)][$past(ev_bit)]);

    // R10: a strobe meeting a clear of the same bit keeps the bit
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && clr_valid && evt_idx == clr_idx && ev_word <= LAST_WORD)
        |=> pend_q[$past(ev_word)][$past(ev_bit)]);

    // R3: strobes to the upper words raise their summary bits
    a_r3_mid_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ev_word == W_MID) |=> pend_q[W_LOW][CASC_MID_BIT]);
    a_r3_high_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ev_word == W_HIGH) |=> pend_q[W_LOW][CASC_HIGH_BIT]);

    // R4: summary bits only fall through a clear request or a word-2 write
    a_r4_summary_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_valid && !(pend_wr && reg_word == W_HIGH))
        |=> ((pend_q[W_LOW][WORD_W-1 -: 2] & $past(pend_q[W_LOW][WORD_W-1 -: 2]))
             == $past(pend_q[W_LOW][WORD_W-1 -: 2])));

    // R5: a software write to word 1 alone leaves it unchanged
    a_r5_mid_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && reg_word == W_MID && !evt_valid && !clr_valid) |=> $stable(pend_q[W_MID]));
endmodule

// File: tb/evt_cascade_irq_bench.sv
`timescale 1ns/1ps
module evt_cascade_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_idx = '0;
    logic        clr_valid = 1'b0;
    logic [6:0]  clr_idx = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq_o;

    always #2.5 clk = ~clk;

    evt_cascade_irq u_evt_cascade_irq (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_idx(evt_idx),
        .clr_valid(clr_valid), .clr_idx(clr_idx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model, built from the requirements
    logic [31:0] mp [3];
    logic [31:0] mm [3][3];

    typedef struct { string tag; logic [2:0] irq; } item_t;
    item_t sb[$];

    function automatic logic [31:0] model_read(logic [3:0] a);
        if (a[1:0] == 2'd3) return 32'h0;
        if (a[3:2] == 2'd0) return mp[a[1:0]];
        return mm[a[3:2] - 2'd1][a[1:0]];
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] r = '0;
        for (int o = 0; o < 3; o++)
            for (int w = 0; w < 3; w++)
                if ((mp[w] & mm[o][w]) != 0) r[o] = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, model update, expected line state queued
    task automatic step(string tag, bit ev, logic [6:0] ei, bit cv, logic [6:0] ci,
                        bit wv, logic [3:0] wa, logic [31:0] wd);
        logic [31:0] clr [3];
        logic [31:0] st [3];
        logic [31:0] nx [3];
        bit t1, t2;
        item_t it;
        @(negedge clk);
        evt_valid = ev; evt_idx = ei; clr_valid = cv; clr_idx = ci;
        reg_wr = wv; reg_addr = wa; reg_wdata = wd;
        for (int w = 0; w < 3; w++) begin clr[w] = '0; st[w] = '0; end
        if (wv && wa[3:2] == 2'd0) begin
            if (wa[1:0] == 2'd0)      clr[0] = wd & 32'h3FFF_FFFF;
            else if (wa[1:0] == 2'd2) clr[2] = wd;
        end
        if (cv && ci[6:5] != 2'd3) clr[ci[6:5]][ci[4:0]] = 1'b1;
        if (ev && ei[6:5] != 2'd3) begin
            st[ei[6:5]][ei[4:0]] = 1'b1;
            if (ei[6:5] == 2'd1) st[0][30] = 1'b1;
            if (ei[6:5] == 2'd2) st[0][31] = 1'b1;
        end
        for (int w = 1; w < 3; w++) nx[w] = (mp[w] & ~clr[w]) | st[w];
        t2 = (wv && wa == 4'h2) || (cv && ci[6:5] == 2'd2);
        t1 = cv && ci[6:5] == 2'd1;
        if (t2 && nx[2] == 0) clr[0][31] = 1'b1;
        if (t1 && nx[1] == 0) clr[0][30] = 1'b1;
        nx[0] = (mp[0] & ~clr[0]) | st[0];
        if (wv && wa[3:2] != 2'd0 && wa[1:0] != 2'd3) mm[wa[3:2] - 2'd1][wa[1:0]] = wd;
        for (int w = 0; w < 3; w++) mp[w] = nx[w];
        @(posedge clk);
        #1;
        evt_valid = 1'b0; clr_valid = 1'b0; reg_wr = 1'b0;
        it.tag = tag; it.irq = model_irq();
        sb.push_back(it);
    endtask

    task automatic check_read(string tag, logic [3:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, model_read(a));
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < 16; a++) check_read(tag, 4'(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int w = 0; w < 3; w++) begin
            mp[w] = '0;
            for (int o = 0; o < 3; o++) mm[o][w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sb.delete();
    endtask

    // monitor: pops expected line states and compares them
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " irq"}, {29'b0, irq_o}, {29'b0, it.irq});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: everything zero after reset
        read_all("R9 reset regs");
        #1 check("R9 reset irq", {29'b0, irq_o}, 32'h0);

        // R11 mask write/readback, R1 + R2 basic event
        step("R11 maskA w0", 0, 0, 0, 0, 1, 4'h4, 32'h0000_0008);
        check_read("R11 maskA readback", 4'h4);
        step("R1 event bit3", 1, 7'h03, 0, 0, 0, 0, 0);
        check_read("R1 word0", 4'h0);

        // R3 cascade from word 1
        step("R2 maskB w0 bit30", 0, 0, 0, 0, 1, 4'h8, 32'h4000_0000);
        step("R3 event w1 bit5", 1, 7'h25, 0, 0, 0, 0, 0);
        check_read("R3 word0 summary", 4'h0);
        check_read("R1 word1", 4'h1);

        // R5 word 1 read-only
        step("R5 write w1", 0, 0, 0, 0, 1, 4'h1, 32'hFFFF_FFFF);
        check_read("R5 word1 kept", 4'h1);

        // R4 word 0 clear keeps summary bits
        step("R4 write w0", 0, 0, 0, 0, 1, 4'h0, 32'hFFFF_FFFF);
        check_read("R4 word0", 4'h0);

        // R7 hardware clear drains word 1 and its summary bit
        step("R7 hw clear w1", 0, 0, 1, 7'h25, 0, 0, 0);
        check_read("R7 word0", 4'h0);
        check_read("R7 word1", 4'h1);

        // R6 word 2 clears and summary drain
        step("R6 maskC w2", 0, 0, 0, 0, 1, 4'hE, 32'h0000_0002);
        step("R3 event w2 bit1", 1, 7'h41, 0, 0, 0, 0, 0);
        step("R3 event w2 bit2", 1, 7'h42, 0, 0, 0, 0, 0);
        check_read("R3 word0 bit31", 4'h0);
        step("R6 write w2 bit1", 0, 0, 0, 0, 1, 4'h2, 32'h0000_0002);
        check_read("R6 word0 still set", 4'h0);
        step("R6 write w2 bit2", 0, 0, 0, 0, 1, 4'h2, 32'h0000_0004);
        check_read("R6 word0 drained", 4'h0);
        check_read("R6 word2", 4'h2);

        // R8 mask change re-evaluates lines without an event
        step("R8 unmasked event", 1, 7'h10, 0, 0, 0, 0, 0);
        step("R8 mask raises A", 0, 0, 0, 0, 1, 4'h4, 32'h0001_0000);
        step("R8 mask drops A", 0, 0, 0, 0, 1, 4'h4, 32'h0000_0000);
        step("R8 maskB w2", 0, 0, 0, 0, 1, 4'hA, 32'h0000_0080);
        step("R2 event w2 bit7", 1, 7'h47, 0, 0, 0, 0, 0);

        // R10 same-cycle event and clear
        step("R10 event+sw clear", 1, 7'h10, 0, 0, 1, 4'h0, 32'h0001_0000);
        check_read("R10 word0 sw", 4'h0);
        step("R10 event+hw clear", 1, 7'h47, 1, 7'h47, 0, 0, 0);
        check_read("R10 word2 hw", 4'h2);
        check_read("R10 word0 hw", 4'h0);
        step("R10 hw clear w2 drains", 0, 0, 1, 7'h47, 0, 0, 0);
        check_read("R7 word0 after w2 drain", 4'h0);

        // R1 invalid word; R11 word field 3
        step("R1 event word3", 1, 7'h63, 0, 0, 0, 0, 0);
        step("R11 write word3", 0, 0, 0, 0, 1, 4'h7, 32'hFFFF_FFFF);
        read_all("R11 after word3 ops");

        // R9 reset mid-run
        step("R9 prep event", 1, 7'h03, 0, 0, 0, 0, 0);
        do_reset();
        read_all("R9 reset again");
        #1 check("R9 irq after reset", {29'b0, irq_o}, 32'h0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule